// File: doc/BRIEF.md
# Grouped-Priority Interrupt Arbiter

The arbiter tracks enable, pending and active state for a parameterised set of interrupt lines. Each line has a 4-bit priority, and a smaller number means more urgent. On every cycle the arbiter works out, from its registered state alone, which enabled pending line should be taken next. It then decides whether that line may interrupt the handler that is already running. A 3-bit grouping field splits each priority into an upper preemption part and a lower subpriority part. Only the preemption part decides whether one handler may preempt another. The full priority still orders the pending lines.

Software reaches the block through one write port. Each write carries an operation code, a line index and a data word. Hardware request pulses on `irqIn` also mark lines pending. The core sees `winValid` and `winId`. It answers with `ackEnter` when it starts the handler and with `ackExit` when the handler returns. A small stack keeps the priority and line of each nested handler, so that the previous level comes back when the inner handler exits.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset, all enable, pending and active bits are 0, `groupOut` is 0, `nestDepth` is 0 and `winValid` is 0.
- R2: The `regOp` codes are 0 = enable set, 1 = enable clear, 2 = pending set and 3 = pending clear, each acting on line `regLine`. A pulse on `irqIn[i]` also sets pending bit i. The changed state is visible on the status outputs in the cycle after the write edge.
- R3: A line whose enable bit is 0 may still be pending, but it is never reported as the winner.
- R4: `regOp` 4 writes `regData[3:0]` as the priority of line `regLine`. Among enabled, pending, non-active lines, the winner has the lowest priority value. If two lines have the same value, the lower line index wins.
- R5: `regOp` 5 stores `regData[10:8]` as the grouping value g. `groupOut` shows the stored value. The preemption part is the top g bits of the priority. Values 5, 6 and 7 act as 4.
- R6: While no handler is active, `winValid` is 1 whenever a winner exists.
- R7: While a handler is active, `winValid` is 1 only if the winner's preemption part is strictly lower than that of the innermost active handler. An equal value waits. With g = 0, nothing preempts.
- R8: When `ackEnter` is high while `winValid` is high, at the next edge the winner's pending bit clears, its active bit sets and `nestDepth` rises by 1. `ackEnter` has no effect while `winValid` is low.
- R9: `ackExit` clears the innermost handler's active bit, lowers `nestDepth` by 1 and restores the previous handler's level for the preemption test. `ackExit` at depth 0 is ignored. When `ackEnter` and `ackExit` are high in the same cycle, only the exit acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | N | Hardware request pulses, one per line |
| regWrEn | input | 1 | Register write strobe |
| regOp | input | 3 | Write operation code |
| regLine | input | clog2(N) | Target line index |
| regData | input | 11 | Write data: priority in [3:0], grouping in [10:8] |
| ackEnter | input | 1 | Core enters the presented handler |
| ackExit | input | 1 | Core leaves the innermost handler |
| winValid | output | 1 | Winner exists and may be taken now |
| winId | output | clog2(N) | Index of the winning line |
| enableOut | output | N | Enable bits |
| pendOut | output | N | Pending bits |
| activeOut | output | N | Active bits |
| groupOut | output | 3 | Stored grouping value |
| nestDepth | output | clog2(N+1) | Number of nested active handlers |

## Verification
Every write, request pulse and acknowledge changes registered state at the clock edge on which it is sampled. The status outputs follow directly from those registers. `winValid` and `winId` are combinational from the same registers, so every result can be seen in the cycle after the stimulus edge. The bench drives stimulus on the falling edge. It holds each stimulus for exactly one rising edge and reads all results on the following falling edge, half a period after the update. Before each arbitration vector, the bench rewrites the whole enable, pending and priority state, so no vector relies on earlier state.

// File: rtl/irqarb_pkg.sv
package irqarb_pkg;
  localparam int PRIO_W  = 4;
  localparam int GROUP_W = 3;

  typedef enum logic [2:0] {
    OP_EN_SET   = 3'd0,
    OP_EN_CLR   = 3'd1,
    OP_PEND_SET = 3'd2,
    OP_PEND_CLR = 3'd3,
    OP_PRIO     = 3'd4,
    OP_GROUP    = 3'd5
  } reg_op_e;

  typedef struct packed {
    logic enSet;
    logic enClr;
    logic pendSet;
    logic pendClr;
    logic prioWr;
    logic grpWr;
    logic enter;
    logic leave;
  } strobe_t;

  // Upper g bits of a priority; g above 4 behaves as 4.
  function automatic logic [PRIO_W-1:0] preemptOf(logic [PRIO_W-1:0] p, logic [GROUP_W-1:0] g);
    case (g)
      3'd0:    return '0;
      3'd1:    return p >> 3;
      3'd2:    return p >> 2;
      3'd3:    return p >> 1;
      default: return p;
    endcase
  endfunction
endpackage

// File: rtl/irqarb_ctrl.sv
module irqarb_ctrl
  import irqarb_pkg::*;
(
  input  logic       regWrEn,
  input  logic [2:0] regOp,
  input  logic       ackEnter,
  input  logic       ackExit,
  input  logic       winValid,
  input  logic       stackEmpty,
  output strobe_t    strb
);
  always_comb begin
    strb = '0;
    if (regWrEn) begin
      case (reg_op_e'(regOp))
        OP_EN_SET:   strb.enSet   = 1'b1;
        OP_EN_CLR:   strb.enClr   = 1'b1;
        OP_PEND_SET: strb.pendSet = 1'b1;
        OP_PEND_CLR: strb.pendClr = 1'b1;
        OP_PRIO:     strb.prioWr  = 1'b1;
        OP_GROUP:    strb.grpWr   = 1'b1;
        default:     ;
      endcase
    end
    strb.leave = ackExit && !stackEmpty;
    strb.enter = ackEnter && !ackExit && winValid;
  end
endmodule

// File: rtl/irqarb_datapath.sv
module irqarb_datapath
  import irqarb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strb,
  input  logic [N-1:0]           irqIn,
  input  logic [$clog2(N)-1:0]   regLine,
  input  logic [10:0]            regData,
  output logic                   winValid,
  output logic [$clog2(N)-1:0]   winId,
  output logic                   stackEmpty,
  output logic [N-1:0]           enableOut,
  output logic [N-1:0]           pendOut,
  output logic [N-1:0]           activeOut,
  output logic [GROUP_W-1:0]     groupOut,
  output logic [$clog2(N+1)-1:0] nestDepth
);
  localparam int IW = $clog2(N);
  localparam int DW = $clog2(N+1);

  logic [N-1:0]        enReg, pendReg, actReg;
  logic [PRIO_W-1:0]   prioReg [N];
  logic [GROUP_W-1:0]  grpReg;
  logic [IW-1:0]       stkId   [N];
  logic [PRIO_W-1:0]   stkPrio [N];
  logic [DW-1:0]       depth;
  logic [IW-1:0]       topIdx;
  logic                unusedBits;

  assign unusedBits = ^regData[7:4];
  assign topIdx     = IW'(depth - DW'(1));
  assign stackEmpty = (depth == '0);

  // Winner search over enabled, pending, non-active lines
  logic [N-1:0]      cand;
  logic              found;
  logic [IW-1:0]     bestId;
  logic [PRIO_W-1:0] bestPrio;

  assign cand = enReg & pendReg & ~actReg;

  always_comb begin
    found    = 1'b0;
    bestId   = '0;
    bestPrio = '1;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || prioReg[i] < bestPrio)) begin
        found    = 1'b1;
        bestId   = IW'(i);
        bestPrio = prioReg[i];
      end
    end
  end

  assign winId    = bestId;
  assign winValid = found && (stackEmpty ||
                    preemptOf(bestPrio, grpReg) < preemptOf(stkPrio[topIdx], grpReg));

  // Per-line state
  for (genvar i = 0; i < N; i++) begin : g_line
    logic hit;
    assign hit = (regLine == IW'(i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enReg[i]   <= 1'b0;
        pendReg[i] <= 1'b0;
        actReg[i]  <= 1'b0;
        prioReg[i] <= '0;
      end else begin
        if (strb.enSet && hit) enReg[i] <= 1'b1;
        if (strb.enClr && hit) enReg[i] <= 1'b0;
        if (strb.prioWr && hit) prioReg[i] <= regData[PRIO_W-1:0];
        if ((strb.enter && bestId == IW'(i)) || (strb.pendClr && hit))
          pendReg[i] <= 1'b0;
        if ((strb.pendSet && hit) || irqIn[i])
          pendReg[i] <= 1'b1;
        if (strb.leave && stkId[topIdx] == IW'(i))
          actReg[i] <= 1'b0;
        else if (strb.enter && bestId == IW'(i))
          actReg[i] <= 1'b1;
      end
    end
  end

  // Nesting stack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grpReg <= '0;
      depth  <= '0;
      for (int k = 0; k < N; k++) begin
        stkId[k]   <= '0;
        stkPrio[k] <= '0;
      end
    end else begin
      if (strb.grpWr) grpReg <= regData[10:8];
      if (strb.leave) begin
        depth <= depth - DW'(1);
      end else if (strb.enter) begin
        stkId[IW'(depth)]   <= bestId;
        stkPrio[IW'(depth)] <= bestPrio;
        depth               <= depth + DW'(1);
      end
    end
  end

  assign enableOut = enReg;
  assign pendOut   = pendReg;
  assign activeOut = actReg;
  assign groupOut  = grpReg;
  assign nestDepth = depth;
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irqarb_pkg::*;
#(
  parameter int N = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [N-1:0]           irqIn,
  input  logic                   regWrEn,
  input  logic [2:0]             regOp,
  input  logic [$clog2(N)-1:0]   regLine,
  input  logic [10:0]            regData,
  input  logic                   ackEnter,
  input  logic                   ackExit,
  output logic                   winValid,
  output logic [$clog2(N)-1:0]   winId,
  output logic [N-1:0]           enableOut,
  output logic [N-1:0]           pendOut,
  output logic [N-1:0]           activeOut,
  output logic [2:0]             groupOut,
  output logic [$clog2(N+1)-1:0] nestDepth
);
  strobe_t strb;
  logic    stackEmpty;

  irqarb_ctrl u_ctrl (
    .regWrEn    (regWrEn),
    .regOp      (regOp),
    .ackEnter   (ackEnter),
    .ackExit    (ackExit),
    .winValid   (winValid),
    .stackEmpty (stackEmpty),
    .strb       (strb)
  );

  irqarb_datapath #(.N(N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .irqIn      (irqIn),
    .regLine    (regLine),
    .regData    (regData),
    .winValid   (winValid),
    .winId      (winId),
    .stackEmpty (stackEmpty),
    .enableOut  (enableOut),
    .pendOut    (pendOut),
    .activeOut  (activeOut),
    .groupOut   (groupOut),
    .nestDepth  (nestDepth)
  );
endmodule

// File: rtl/irqarb_checker.sv
module irqarb_checker #(
  parameter int N = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   ackEnter,
  input logic                   ackExit,
  input logic                   winValid,
  input logic [$clog2(N)-1:0]   winId,
  input logic [N-1:0]           enableOut,
  input logic [N-1:0]           pendOut,
  input logic [N-1:0]           activeOut,
  input logic [2:0]             groupOut,
  input logic [$clog2(N+1)-1:0] nestDepth
);
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (enableOut[winId] && pendOut[winId])); // R3

  AST_IDLE_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (nestDepth == 0 && |(enableOut & pendOut & ~activeOut)) |-> winValid); // R6

  AST_GROUP0_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (groupOut == 3'd0 && nestDepth != 0) |-> !winValid); // R7

  AST_ENTER_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (ackEnter && !ackExit && winValid) |=>
      (activeOut[$past(winId)] && nestDepth == $past(nestDepth) + 1)); // R8

  AST_EXIT_DEPTH: assert property (@(posedge clk) disable iff (!rstN)
    (ackExit && nestDepth != 0) |=> (nestDepth == $past(nestDepth) - 1)); // R9

  AST_ACTIVE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(activeOut) == int'(nestDepth)); // R9
endmodule

bind irq_prio_arbiter irqarb_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ackEnter  (ackEnter),
  .ackExit   (ackExit),
  .winValid  (winValid),
  .winId     (winId),
  .enableOut (enableOut),
  .pendOut   (pendOut),
  .activeOut (activeOut),
  .groupOut  (groupOut),
  .nestDepth (nestDepth)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       regWrEn = 1'b0;
  logic [2:0] regOp = '0;
  logic [2:0] regLine = '0;
  logic [10:0] regData = '0;
  logic       ackEnter = 1'b0;
  logic       ackExit = 1'b0;
  logic       winValid;
  logic [2:0] winId;
  logic [7:0] enableOut, pendOut, activeOut;
  logic [2:0] groupOut;
  logic [3:0] nestDepth;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  irq_prio_arbiter #(.N(N)) u_irq_prio_arbiter (.*);

  // {enable[7:0], pending[7:0], priorities line7..line0 [31:0], expValid, expId[2:0]}
  localparam logic [51:0] VEC [7] = '{
    {8'hFF, 8'h00, 32'h0000_0000, 1'b0, 3'd0},
    {8'hFF, 8'h24, 32'h0000_0000, 1'b1, 3'd2},
    {8'hFF, 8'h24, 32'h0010_0300, 1'b1, 3'd5},
    {8'hDF, 8'h24, 32'h0010_0300, 1'b1, 3'd2},
    {8'h00, 8'hFF, 32'h0000_0000, 1'b0, 3'd0},
    {8'hFF, 8'h81, 32'h0000_0004, 1'b1, 3'd7},
    {8'hFF, 8'hFE, 32'h1111_1111, 1'b1, 3'd1}
  };

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input int line, input logic [10:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regOp = op; regLine = 3'(line); regData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic ack(input logic ent, input logic ext);
    @(negedge clk);
    ackEnter = ent; ackExit = ext;
    @(negedge clk);
    ackEnter = 1'b0; ackExit = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 enable", int'(enableOut), 0);
    check("R1 pending", int'(pendOut), 0);
    check("R1 active", int'(activeOut), 0);
    check("R1 group", int'(groupOut), 0);
    check("R1 depth", int'(nestDepth), 0);
    check("R1 winValid", int'(winValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: R4 ordering, R3 disabled lines, R6 idle presentation
    for (int v = 0; v < 7; v++) begin
      for (int i = 0; i < N; i++) begin
        wr(VEC[v][51-7+i] ? 3'd0 : 3'd1, i, '0);
        wr(3'd3, i, '0);
        wr(3'd4, i, 11'(VEC[v][4+4*i +: 4]));
      end
      for (int i = 0; i < N; i++)
        if (VEC[v][43-7+i]) wr(3'd2, i, '0);
      check($sformatf("R4 R6 vec%0d valid", v), int'(winValid), int'(VEC[v][3]));
      if (VEC[v][3]) check($sformatf("R4 R3 vec%0d id", v), int'(winId), int'(VEC[v][2:0]));
    end

    // Clean slate, all lines disabled
    for (int i = 0; i < N; i++) begin wr(3'd1, i, '0); wr(3'd3, i, '0); end

    // R2 hardware pulse on disabled line, R3 no win
    @(negedge clk); irqIn = 8'h08; @(negedge clk); irqIn = '0;
    check("R2 irq pulse pending", int'(pendOut), 8);
    check("R3 disabled no win", int'(winValid), 0);
    wr(3'd3, 3, '0);
    check("R2 pending clear", int'(pendOut), 0);
    wr(3'd0, 6, '0);
    check("R2 enable set", int'(enableOut), 8'h40);

    // R5/R7/R8/R9 nested scenario with grouping 2
    wr(3'd5, 0, 11'h200);
    check("R5 group stored", int'(groupOut), 2);
    wr(3'd4, 1, 11'd8); wr(3'd4, 2, 11'd4); wr(3'd4, 3, 11'd9);
    for (int i = 1; i < 4; i++) wr(3'd0, i, '0);
    wr(3'd1, 6, '0);
    ack(1'b1, 1'b0);
    check("R8 enter without winner ignored", int'(nestDepth), 0);
    wr(3'd2, 1, '0);
    check("R6 idle winner", int'(winId), 1);
    ack(1'b1, 1'b0);
    check("R8 active set", int'(activeOut), 8'h02);
    check("R8 pending cleared", int'(pendOut), 0);
    check("R8 depth", int'(nestDepth), 1);
    wr(3'd2, 3, '0);
    check("R7 equal preempt waits", int'(winValid), 0);
    wr(3'd2, 2, '0);
    check("R7 lower preempt valid", int'(winValid), 1);
    check("R7 lower preempt id", int'(winId), 2);
    ack(1'b1, 1'b0);
    check("R8 nested depth", int'(nestDepth), 2);
    check("R7 blocked under deeper level", int'(winValid), 0);
    ack(1'b0, 1'b1);
    check("R9 exit depth", int'(nestDepth), 1);
    check("R9 exit active", int'(activeOut), 8'h02);
    check("R9 restored level blocks equal", int'(winValid), 0);
    wr(3'd5, 0, 11'h400);
    wr(3'd4, 3, 11'd7);
    check("R5 g4 full compare", int'(winValid), 1);
    wr(3'd5, 0, 11'h000);
    check("R7 g0 never preempts", int'(winValid), 0);
    ack(1'b0, 1'b1);
    check("R9 back to idle", int'(nestDepth), 0);
    check("R6 idle presents line3", int'(winValid), 1);
    ack(1'b0, 1'b1);
    check("R9 exit at depth0 ignored", int'(nestDepth), 0);
    ack(1'b1, 1'b1);
    check("R9 enter+exit depth", int'(nestDepth), 0);
    check("R9 enter+exit pending kept", int'(pendOut), 8'h08);

    // R5 values 5..7 behave as 4
    ack(1'b1, 1'b0);
    check("R8 enter line3", int'(activeOut), 8'h08);
    wr(3'd4, 2, 11'd6);
    wr(3'd2, 2, '0);
    wr(3'd5, 0, 11'h200);
    check("R5 g2 6 vs 7 equal", int'(winValid), 0);
    wr(3'd5, 0, 11'h600);
    check("R5 g6 stored", int'(groupOut), 6);
    check("R5 g6 acts as 4", int'(winValid), 1);

    // Reset returns to idle
    @(negedge clk); rstN = 1'b0; @(negedge clk);
    check("R1 reset again depth", int'(nestDepth), 0);
    check("R1 reset again active", int'(activeOut), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule